// File: doc/BRIEF.md
# Serial Display Byte Writer

This block sends one byte at a time to a serial graphic display controller over four wires: an active-low chip select, a data/command select line, a serial clock and a serial data line. A host places a byte and a data/command flag on the inputs and pulses `start` for one cycle. The block then asserts chip select, drives the data/command line to match the flag, and shifts the byte out most significant bit first. The receiver samples data on each rising clock edge. Chip select is released after the eighth bit and a one-cycle `done` pulse follows.

Every bit period has three parts. First comes one system cycle with the serial clock low and the data line cleared. Next come N cycles with the clock still low and the bit value on the data line. Last come N cycles with the clock high. N is the programmed half-period length `half_div + 1`. The byte, the flag and the divider value are captured when the transfer is accepted, so the host may change them while a transfer runs.

Top module: `sdisp_byte_writer`

## Requirements
- R1: After reset and between transfers, `cs_n` is 1, `sclk` is 1, `sdata` is 0, `busy` is 0 and `done` is 0.
- R2: A `start` seen while `busy` is 0 begins a transfer. `cs_n` goes low in the next cycle and stays low for exactly 8*(2N+1) consecutive cycles, where N = `half_div` + 1.
- R3: During a transfer `sclk` has exactly eight rising edges. The data values present at those edges, in order, are `byte_in` bit 7 down to bit 0.
- R4: `dc` is 1 throughout the transfer when `is_data` was 1 at acceptance, and 0 throughout when it was 0.
- R5: Each bit period is laid out as follows. One cycle with `sclk`=0 and `sdata`=0. Then N cycles with `sclk`=0 and `sdata` equal to the bit. Then N cycles with `sclk`=1 and `sdata` still equal to the bit.
- R6: A `start` pulse while `busy` is 1 has no effect. The running transfer is unchanged and no further transfer follows it.
- R7: `busy` is 1 in exactly the cycles where `cs_n` is 0.
- R8: `done` is 1 for exactly one cycle, the first cycle in which `cs_n` is high again after a transfer, and is 0 at all other times.
- R9: Changes on `byte_in`, `is_data` or `half_div` after acceptance do not affect the running transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to send the presented byte |
| byte_in | input | 8 | Byte to send |
| is_data | input | 1 | 1 = display data byte, 0 = command byte |
| half_div | input | 8 | Half-period length minus one, in system cycles |
| cs_n | output | 1 | Active-low chip select to the display |
| dc | output | 1 | Data/command select to the display |
| sclk | output | 1 | Serial clock, idles high |
| sdata | output | 1 | Serial data, MSB first |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after chip select is released |

## Verification
A wrong bit counter or a wrong half-period counter shows up at the ports within one frame. The chip-select window then has the wrong length, or the count of rising clock edges is not eight. The bench measures every low and high clock run against N, so a divider error appears in the first bit period. A broken shift register or a bad latch shows up as a wrong reassembled byte when chip select rises. A transition error in the state machine shows up as a missing clear cycle, a `done` pulse out of place, or a second frame after an ignored start. Each of these is visible a few cycles after the fault.

// File: rtl/sdw_pkg.sv
// Shared types for the serial display byte writer.
// Assumes: a single clock domain. The phase encoding is local to this block.
package sdw_pkg;
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_CLR  = 3'd1,
        PH_LOW  = 3'd2,
        PH_HIGH = 3'd3,
        PH_FIN  = 3'd4
    } sdw_phase_t;
endpackage

// File: rtl/sdw_half_timer.sv
// Half-period timer. It counts system cycles while run is high.
// expire is high in the cycle that reaches len, so one half period lasts len+1 cycles.
// Assumes: len is stable while run is high, and restart comes before each half period.
module sdw_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] len,
    output logic             expire
);
    logic [DIV_W-1:0] cnt_q;

    // Count cycles in the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (restart)          cnt_q <= '0;
        else if (run && !expire)   cnt_q <= cnt_q + 1'b1;
    end

    // Flag the last cycle of the half period.
    always_comb expire = run && (cnt_q == len);

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= len));
endmodule

// File: rtl/sdw_bit_shifter.sv
// MSB-first shift register with a count of the bits still to go.
// load captures a fresh byte. shift moves on to the next bit.
// Assumes: load and shift are never high together.
module sdw_bit_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] din,
    output logic              msb,
    output logic              last
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    logic [DATA_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;

    // Hold the byte and step through it, top bit first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            sh_q  <= din;
            cnt_q <= CNT_W'(DATA_W - 1);
        end else if (shift) begin
            sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Present the current bit and mark the final one.
    always_comb begin
        msb  = sh_q[DATA_W-1];
        last = (cnt_q == '0);
    end

    // R3
    load_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == CNT_W'(DATA_W - 1)));

    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> !last);
endmodule

// File: rtl/sdw_frame_ctrl.sv
// Frame sequencer. Per bit it steps through a clear cycle, a low half and a high half.
// It releases chip select after the final bit and then gives one finish cycle.
// Assumes: expire comes from a timer that it restarts, and last from the bit shifter.
module sdw_frame_ctrl
    import sdw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic expire,
    input  logic last,
    output logic accept,
    output logic tmr_run,
    output logic tmr_restart,
    output logic sh_shift,
    output logic cs_n,
    output logic sclk_o,
    output logic data_en,
    output logic busy,
    output logic done
);
    sdw_phase_t st_q, st_d;

    // Choose the next phase.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PH_IDLE, PH_FIN: st_d = start ? PH_CLR : PH_IDLE;
            PH_CLR:          st_d = PH_LOW;
            PH_LOW:          if (expire) st_d = PH_HIGH;
            PH_HIGH:         if (expire) st_d = last ? PH_FIN : PH_CLR;
            default:         st_d = PH_IDLE;
        endcase
    end

    // Register the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= PH_IDLE;
        else        st_q <= st_d;
    end

    // Derive the controls and the line levels from the phase.
    always_comb begin
        accept      = ((st_q == PH_IDLE) || (st_q == PH_FIN)) && start;
        tmr_run     = (st_q == PH_LOW) || (st_q == PH_HIGH);
        tmr_restart = (st_q == PH_CLR) || ((st_q == PH_LOW) && expire);
        sh_shift    = (st_q == PH_HIGH) && expire && !last;
        busy        = (st_q == PH_CLR) || (st_q == PH_LOW) || (st_q == PH_HIGH);
        cs_n        = !busy;
        sclk_o      = !((st_q == PH_CLR) || (st_q == PH_LOW));
        data_en     = (st_q == PH_LOW) || (st_q == PH_HIGH);
        done        = (st_q == PH_FIN);
    end

    // R6
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));
endmodule

// File: rtl/sdisp_byte_writer.sv
// Top of the serial display byte writer.
// It captures the byte, the data/command flag and the divider on acceptance,
// then drives the four-wire link through the sequencer, the timer and the shifter.
// Assumes: start is synchronous to clk. A start while busy is dropped.
module sdisp_byte_writer #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              is_data,
    input  logic [DIV_W-1:0]  half_div,
    output logic              cs_n,
    output logic              dc,
    output logic              sclk,
    output logic              sdata,
    output logic              busy,
    output logic              done
);
    logic             accept, tmr_run, tmr_restart, sh_shift;
    logic             expire, last, msb, data_en;
    logic             dc_q;
    logic [DIV_W-1:0] div_q;

    // Capture the byte type and the half-period length at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dc_q  <= 1'b0;
            div_q <= '0;
        end else if (accept) begin
            dc_q  <= is_data;
            div_q <= half_div;
        end
    end

    sdw_frame_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .expire(expire), .last(last),
        .accept(accept), .tmr_run(tmr_run), .tmr_restart(tmr_restart),
        .sh_shift(sh_shift), .cs_n(cs_n), .sclk_o(sclk), .data_en(data_en),
        .busy(busy), .done(done)
    );

    sdw_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(tmr_run), .restart(tmr_restart),
        .len(div_q), .expire(expire)
    );

    sdw_bit_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(accept), .shift(sh_shift),
        .din(byte_in), .msb(msb), .last(last)
    );

    // Drive the serial lines. Data is cleared outside the bit halves.
    always_comb begin
        sdata = data_en && msb;
        dc    = dc_q;
    end

    // R4
    dc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(dc));

    // R5
    bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $fell(sclk)) |-> !sdata);

    // R5
    rise_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $rose(sclk)) |-> $stable(sdata));

    // R8
    done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !$past(cs_n)));
endmodule

// File: tb/sdisp_byte_writer_bench.sv
module sdisp_byte_writer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       is_data = 1'b0;
    logic [7:0] half_div = 8'h00;
    logic       cs_n, dc, sclk, sdata, busy, done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int frames = 0;

    logic [7:0] exp_byte = 8'h00;
    logic       exp_dc = 1'b0;
    int         exp_n = 1;
    bit         poke_mode = 1'b0;

    sdisp_byte_writer u_sdisp_byte_writer (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_in(byte_in),
        .is_data(is_data), .half_div(half_div), .cs_n(cs_n), .dc(dc),
        .sclk(sclk), .sdata(sdata), .busy(busy), .done(done)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            chk(1'b0, "watchdog", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Port monitor: rebuilds each frame from the lines
    bit         prev_cs = 1'b1, prev_sclk = 1'b1, dc_bad = 1'b0;
    int         run_len = 0, rises = 0, cs_cnt = 0;
    logic [7:0] cap = 8'h00;
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_cs = 1'b1; prev_sclk = 1'b1;
        end else begin
            chk(busy == !cs_n, "R7 busy vs cs_n", busy, !cs_n);
            if (!cs_n) begin
                if (prev_cs) begin
                    cs_cnt = 0; rises = 0; cap = 8'h00; dc_bad = 1'b0; run_len = 0;
                end
                cs_cnt++;
                if (dc !== exp_dc) dc_bad = 1'b1;
                if (prev_cs || (prev_sclk && !sclk))
                    chk(!sclk && !sdata, "R5 clear cycle", {sclk, sdata}, 0);
                if (prev_cs) run_len = 1;
                else if (sclk == prev_sclk) run_len++;
                else begin
                    if (prev_sclk) chk(run_len == exp_n, "R5 high run", run_len, exp_n);
                    else chk(run_len == exp_n + 1, "R5 low run", run_len, exp_n + 1);
                    run_len = 1;
                end
                if (sclk && !prev_sclk) begin
                    cap = {cap[6:0], sdata};
                    rises++;
                end
            end else if (!prev_cs) begin
                chk(prev_sclk && run_len == exp_n, "R5 last high run", run_len, exp_n);
                chk(done && !busy, "R8 done at release", done, 1);
                chk(cap == exp_byte, poke_mode ? "R9 latched byte" : "R3 byte order",
                    cap, exp_byte);
                chk(rises == 8, "R3 rise count", rises, 8);
                chk(cs_cnt == 8 * (2 * exp_n + 1), "R2 cs window", cs_cnt,
                    8 * (2 * exp_n + 1));
                chk(!dc_bad, "R4 dc level", dc_bad, 0);
                frames++;
            end else begin
                chk(sclk && !sdata && !done && !busy, "R1 idle lines",
                    {sclk, sdata, done, busy}, 8);
            end
            prev_cs = cs_n;
            prev_sclk = sclk;
        end
    end

    task automatic send(input logic [7:0] b, input logic d, input logic [7:0] dv, input bit poke);
        int want;
        bit seen;
        want = frames + 1;
        @(negedge clk);
        exp_byte = b; exp_dc = d; exp_n = int'(dv) + 1; poke_mode = poke;
        byte_in = b; is_data = d; half_div = dv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk);
            @(negedge clk);
            byte_in = ~b; is_data = !d; half_div = dv + 8'd3; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        seen = 1'b0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            if (done) seen = 1'b1;
            else @(negedge clk);
        end
        chk(seen, "R8 done seen", seen, 1);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk(frames == want, poke ? "R6 one frame only" : "R2 frame count", frames, want);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cs_n && sclk && !sdata && !busy && !done, "R1 reset state",
            {cs_n, sclk, sdata, busy, done}, 24);
        for (int b = 0; b < 256; b++)
            send(8'(b), b[0], 8'd0, 1'b0);
        for (int dv = 1; dv <= 3; dv++)
            for (int b = 0; b < 32; b++)
                send(8'((b * 37 + dv * 11) & 255), b[1], 8'(dv), 1'b0);
        send(8'hA5, 1'b1, 8'd5, 1'b1);
        send(8'h3C, 1'b0, 8'd0, 1'b1);
        send(8'hFF, 1'b1, 8'd2, 1'b1);
        send(8'h00, 1'b0, 8'd1, 1'b1);
        send(8'h81, 1'b1, 8'd15, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule